// File: doc/BRIEF.md
# Saturating Fixed-Point Arithmetic Unit

This unit performs signed two's-complement arithmetic on two operands that share a single fixed-point format. The format has `W` total bits, of which `F` are fraction bits, and defaults to 21 bits with 10 fraction bits. A 2-bit opcode selects one of four operations: add, subtract, multiply, or narrowing a wider fixed-point value into the operand format.

Each operation first forms its result at full precision, keeping track of where the binary point sits. It then shifts the result back to `F` fraction bits. This shift truncates toward negative infinity. If the integer part no longer fits, the result is clamped to the most positive or most negative code. It does not wrap.

Two flags report clamping. One flag marks a clamp to the top of the range and the other marks a clamp to the bottom.

Operands are sampled on a clock edge when the valid strobe is high. The result, both flags and an output valid strobe appear on the registered outputs one clock later.

Top module: `fxp_alu`

## Requirements
- R1: With opcode 2'b00, the result is a+b, taken at full precision (one extra bit) and saturated to the W-bit range. Two operands of opposite sign never set a flag.
- R2: With opcode 2'b01, the result is a-b, taken at full precision and saturated to the W-bit range.
- R3: With opcode 2'b10, the full product carries 2F fraction bits. Its low F bits are dropped (rounding toward negative infinity), and the remaining value is saturated to the W-bit range. A zero operand gives a zero result with no flag.
- R4: A multiply of the most negative code by itself yields the most positive code with the overflow flag set.
- R5: With opcode 2'b11, the value on `wide_i` is narrowed into the output format. This value has XW bits and XF fraction bits, with XF ≥ F. Its low XF-F bits are dropped (truncation toward negative infinity), and the rest is saturated to W bits.
- R6: `ovf_o` is high exactly when the true result exceeds the most positive code. In that case `res_o` holds that code, 0 followed by W-1 ones.
- R7: `unf_o` is high exactly when the true result is below the most negative code. In that case `res_o` holds that code, 1 followed by W-1 zeros. `ovf_o` and `unf_o` are never high together.
- R8: `valid_o` is high in the cycle after `valid_i` was sampled high, and low otherwise. While `valid_i` is low, `res_o` and both flags keep their values.
- R9: A synchronous active-high reset clears `res_o`, `ovf_o`, `unf_o` and `valid_o` to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_i | input | 1 | Operands and opcode are valid this cycle |
| op_i | input | 2 | 00 add, 01 subtract, 10 multiply, 11 narrow `wide_i` |
| a_i | input | W | Operand A, W bits with F fraction bits |
| b_i | input | W | Operand B, same format as A |
| wide_i | input | XW | Wide value for the narrowing operation, XF fraction bits |
| valid_o | output | 1 | Result valid, one clock after `valid_i` |
| res_o | output | W | Saturated result, W bits with F fraction bits |
| ovf_o | output | 1 | Result was clamped to the most positive code |
| unf_o | output | 1 | Result was clamped to the most negative code |

## Verification
The datapath is purely combinational into a single register stage. Any fault in an adder, the product slice or a saturator therefore shows up on `res_o` or the flags in the cycle right after the faulty operation is sampled.

A misplaced binary point or a wrong truncation direction shows up on small negative products and on narrowed values as an off-by-one or a scaled result. Clamp faults show up only near the range edges, so the bench weights operands toward the extreme codes.

A fault in the hold path or the valid path shows up one cycle after an idle cycle, when the outputs must not change.

// File: rtl/fxp_pkg.sv
package fxp_pkg;

  typedef enum logic [1:0] {
    OP_ADD = 2'b00,
    OP_SUB = 2'b01,
    OP_MUL = 2'b10,
    OP_RSZ = 2'b11
  } fxp_op_e;

endpackage

// File: rtl/fxp_narrow.sv
// Rescale a signed fixed-point value to fewer fraction bits (truncating
// toward negative infinity), then clamp the integer part to OW bits.
module fxp_narrow #(
  parameter int IW = 22,
  parameter int IF = 10,
  parameter int OW = 21,
  parameter int OF = 10
) (
  input  logic signed [IW-1:0] din,
  output logic signed [OW-1:0] dout,
  output logic                 hi_clip,
  output logic                 lo_clip
);
  localparam int SH = IF - OF;

  logic signed [IW-1:0] shifted;
  assign shifted = din >>> SH;

  generate
    if (IW > OW) begin : g_clip
      localparam int HB = IW - OW + 1;
      logic [HB-1:0] top;
      logic          fits;

      assign top  = shifted[IW-1:OW-1];
      assign fits = (top == '0) || (top == '1);

      always_comb begin
        hi_clip = !fits && !din[IW-1];
        lo_clip = !fits &&  din[IW-1];
        if (hi_clip)      dout = {1'b0, {(OW-1){1'b1}}};
        else if (lo_clip) dout = {1'b1, {(OW-1){1'b0}}};
        else              dout = shifted[OW-1:0];
      end
    end else begin : g_ext
      assign dout    = OW'(shifted);
      assign hi_clip = 1'b0;
      assign lo_clip = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/fxp_addsub.sv
// Full-precision add/subtract: one guard bit above the operand width.
module fxp_addsub #(
  parameter int W = 21
) (
  input  logic signed [W-1:0] a,
  input  logic signed [W-1:0] b,
  input  logic                sub,
  output logic signed [W:0]   sum
);
  logic signed [W:0] ax, bx;

  assign ax  = {a[W-1], a};
  assign bx  = {b[W-1], b};
  assign sum = sub ? (ax - bx) : (ax + bx);
endmodule

// File: rtl/fxp_mul.sv
// Signed product kept in 2W-1 bits. The only code that needs the top
// bit (most negative squared) is replaced by the largest kept value.
module fxp_mul #(
  parameter int W = 21
) (
  input  logic signed [W-1:0]   a,
  input  logic signed [W-1:0]   b,
  output logic signed [2*W-2:0] prod
);
  localparam int PW = 2*W - 1;
  localparam logic [W-1:0] MIN_CODE = {1'b1, {(W-1){1'b0}}};

  logic signed [PW-1:0] raw;
  logic                 both_min;

  assign raw      = PW'(a) * PW'(b);
  assign both_min = (a == MIN_CODE) && (b == MIN_CODE);
  assign prod     = both_min ? {1'b0, {(PW-1){1'b1}}} : raw;
endmodule

// File: rtl/fxp_alu.sv
module fxp_alu
  import fxp_pkg::*;
#(
  parameter int W  = 21,
  parameter int F  = 10,
  parameter int XW = 32,
  parameter int XF = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          valid_i,
  input  logic [1:0]    op_i,
  input  logic [W-1:0]  a_i,
  input  logic [W-1:0]  b_i,
  input  logic [XW-1:0] wide_i,
  output logic          valid_o,
  output logic [W-1:0]  res_o,
  output logic          ovf_o,
  output logic          unf_o
);
  localparam int SW = W + 1;
  localparam int PW = 2*W - 1;

  logic signed [W-1:0]  sa, sb;
  logic signed [SW-1:0] sum_full;
  logic signed [PW-1:0] prod_full;
  logic signed [W-1:0]  sum_n, prod_n, wide_n;
  logic                 sum_hi, sum_lo, prod_hi, prod_lo, wide_hi, wide_lo;

  logic [W-1:0] nxt_res;
  logic         nxt_hi, nxt_lo;

  assign sa = $signed(a_i);
  assign sb = $signed(b_i);

  fxp_addsub #(.W(W)) u_addsub (
    .a   (sa),
    .b   (sb),
    .sub (op_i == OP_SUB),
    .sum (sum_full)
  );

  fxp_narrow #(.IW(SW), .IF(F), .OW(W), .OF(F)) u_sat_sum (
    .din     (sum_full),
    .dout    (sum_n),
    .hi_clip (sum_hi),
    .lo_clip (sum_lo)
  );

  fxp_mul #(.W(W)) u_mul (
    .a    (sa),
    .b    (sb),
    .prod (prod_full)
  );

  fxp_narrow #(.IW(PW), .IF(2*F), .OW(W), .OF(F)) u_sat_prod (
    .din     (prod_full),
    .dout    (prod_n),
    .hi_clip (prod_hi),
    .lo_clip (prod_lo)
  );

  fxp_narrow #(.IW(XW), .IF(XF), .OW(W), .OF(F)) u_sat_wide (
    .din     ($signed(wide_i)),
    .dout    (wide_n),
    .hi_clip (wide_hi),
    .lo_clip (wide_lo)
  );

  always_comb begin
    case (fxp_op_e'(op_i))
      OP_ADD, OP_SUB: begin
        nxt_res = sum_n;  nxt_hi = sum_hi;  nxt_lo = sum_lo;
      end
      OP_MUL: begin
        nxt_res = prod_n; nxt_hi = prod_hi; nxt_lo = prod_lo;
      end
      default: begin
        nxt_res = wide_n; nxt_hi = wide_hi; nxt_lo = wide_lo;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_o <= 1'b0;
      res_o   <= '0;
      ovf_o   <= 1'b0;
      unf_o   <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        res_o <= nxt_res;
        ovf_o <= nxt_hi;
        unf_o <= nxt_lo;
      end
    end
  end
endmodule

// File: rtl/fxp_alu_chk.sv
module fxp_alu_chk #(
  parameter int W  = 21,
  parameter int F  = 10,
  parameter int XW = 32,
  parameter int XF = 12
) (
  input logic          clk,
  input logic          rst,
  input logic          valid_i,
  input logic [1:0]    op_i,
  input logic [W-1:0]  a_i,
  input logic [W-1:0]  b_i,
  input logic [XW-1:0] wide_i,
  input logic          valid_o,
  input logic [W-1:0]  res_o,
  input logic          ovf_o,
  input logic          unf_o
);
  localparam logic [W-1:0] MAXC = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] MINC = {1'b1, {(W-1){1'b0}}};

  p_flags_excl_r7: assert property (@(posedge clk) disable iff (rst)
    !(ovf_o && unf_o));

  p_ovf_max_r6: assert property (@(posedge clk) disable iff (rst)
    ovf_o |-> (res_o == MAXC));

  p_unf_min_r7: assert property (@(posedge clk) disable iff (rst)
    unf_o |-> (res_o == MINC));

  p_valid_lag_r8: assert property (@(posedge clk) disable iff (rst)
    (valid_i && !rst) |=> valid_o);

  p_valid_idle_r8: assert property (@(posedge clk) disable iff (rst)
    (!valid_i && !rst) |=> !valid_o);

  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (!valid_i && !rst) |=> ($stable(res_o) && $stable(ovf_o) && $stable(unf_o)));

  p_no_clip_mixed_r1: assert property (@(posedge clk) disable iff (rst)
    (valid_i && op_i == 2'b00 && (a_i[W-1] != b_i[W-1])) |=> (!ovf_o && !unf_o));

  p_min_sq_r4: assert property (@(posedge clk) disable iff (rst)
    (valid_i && op_i == 2'b10 && a_i == MINC && b_i == MINC) |=> (ovf_o && res_o == MAXC));

  p_mul_zero_r3: assert property (@(posedge clk) disable iff (rst)
    (valid_i && op_i == 2'b10 && a_i == '0) |=> (res_o == '0 && !ovf_o && !unf_o));
endmodule

bind fxp_alu fxp_alu_chk #(.W(W), .F(F), .XW(XW), .XF(XF)) u_chk (
  .clk(clk), .rst(rst), .valid_i(valid_i), .op_i(op_i), .a_i(a_i), .b_i(b_i),
  .wide_i(wide_i), .valid_o(valid_o), .res_o(res_o), .ovf_o(ovf_o), .unf_o(unf_o)
);

// File: tb/tb_fxp_alu.sv
module tb_fxp_alu;
  localparam int W  = 21;
  localparam int F  = 10;
  localparam int XW = 32;
  localparam int XF = 12;
  localparam longint MAXV = (64'sd1 <<< (W-1)) - 1;
  localparam longint MINV = -(64'sd1 <<< (W-1));

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          valid_i = 1'b0;
  logic [1:0]    op_i = 2'b00;
  logic [W-1:0]  a_i = '0;
  logic [W-1:0]  b_i = '0;
  logic [XW-1:0] wide_i = '0;
  logic          valid_o;
  logic [W-1:0]  res_o;
  logic          ovf_o, unf_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  fxp_alu #(.W(W), .F(F), .XW(XW), .XF(XF)) dut (
    .clk(clk), .rst(rst), .valid_i(valid_i), .op_i(op_i), .a_i(a_i), .b_i(b_i),
    .wide_i(wide_i), .valid_o(valid_o), .res_o(res_o), .ovf_o(ovf_o), .unf_o(unf_o)
  );

  // Reference model: true value, then clamp.
  function automatic longint ref_val(input logic [1:0] op, input logic [W-1:0] a,
                                     input logic [W-1:0] b, input logic [XW-1:0] w);
    longint sa = $signed(a);
    longint sb = $signed(b);
    longint sw = $signed(w);
    case (op)
      2'b00:   return sa + sb;
      2'b01:   return sa - sb;
      2'b10:   return (sa * sb) >>> F;
      default: return sw >>> (XF - F);
    endcase
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  task automatic check(input string tag, input logic [W-1:0] exp_res, input logic exp_ovf,
                       input logic exp_unf, input logic exp_vld);
    n_chk++;
    if (res_o !== exp_res || ovf_o !== exp_ovf || unf_o !== exp_unf || valid_o !== exp_vld) begin
      n_bad++;
      $display("FAIL %s: got res=%h ovf=%b unf=%b vld=%b, expected res=%h ovf=%b unf=%b vld=%b",
               tag, res_o, ovf_o, unf_o, valid_o, exp_res, exp_ovf, exp_unf, exp_vld);
    end
  endtask

  logic [W-1:0] last_res;
  logic         last_ovf, last_unf;

  task automatic run_op(input logic [1:0] op, input logic [W-1:0] a, input logic [W-1:0] b,
                        input logic [XW-1:0] w);
    longint v;
    logic [W-1:0] er;
    logic eo, eu;
    string tag;
    @(negedge clk);
    op_i = op; a_i = a; b_i = b; wide_i = w; valid_i = 1'b1;
    @(negedge clk);
    valid_i = 1'b0;
    v  = ref_val(op, a, b, w);
    eo = (v > MAXV);
    eu = (v < MINV);
    er = eo ? MAXV[W-1:0] : (eu ? MINV[W-1:0] : v[W-1:0]);
    case (op)
      2'b00:   tag = "R1 add";
      2'b01:   tag = "R2 sub";
      2'b10:   tag = (a == MINV[W-1:0] && b == MINV[W-1:0]) ? "R4 min squared" : "R3 mul";
      default: tag = "R5 resize";
    endcase
    if (eo) tag = {tag, " R6"};
    if (eu) tag = {tag, " R7"};
    check(tag, er, eo, eu, 1'b1);
    last_res = er; last_ovf = eo; last_unf = eu;
  endtask

  function automatic logic [W-1:0] pick_operand();
    case ($urandom_range(0, 5))
      0:       return MAXV[W-1:0];
      1:       return MINV[W-1:0];
      2:       return W'($urandom_range(0, 4096));
      3:       return W'(-$signed({1'b0, $urandom_range(0, 4096)}));
      default: return W'($urandom);
    endcase
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout, expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    @(negedge clk);
    @(negedge clk);
    check("R9 reset", '0, 1'b0, 1'b0, 1'b0);
    rst = 1'b0;

    // Directed corner cases
    run_op(2'b00, MAXV[W-1:0], MAXV[W-1:0], '0);            // R1 + R6
    run_op(2'b00, MINV[W-1:0], MINV[W-1:0], '0);            // R1 + R7
    run_op(2'b00, MAXV[W-1:0], MINV[W-1:0], '0);            // R1 mixed signs
    run_op(2'b00, W'(3 << F), W'(-(5 << F)), '0);           // R1 integer conversion
    run_op(2'b01, MINV[W-1:0], W'(1), '0);                  // R2 + R7
    run_op(2'b01, MAXV[W-1:0], MINV[W-1:0], '0);            // R2 + R6
    run_op(2'b01, W'(1234), W'(1234), '0);                  // R2 zero
    run_op(2'b10, MINV[W-1:0], MINV[W-1:0], '0);            // R4
    run_op(2'b10, MINV[W-1:0], MAXV[W-1:0], '0);            // R3 + R7
    run_op(2'b10, '1, W'(1), '0);                           // R3 floor of -1 lsb
    run_op(2'b10, W'(3 << F), W'(2560), '0);                // R3 3.0 * 2.5
    run_op(2'b10, '0, MINV[W-1:0], '0);                     // R3 zero operand
    run_op(2'b11, '0, '0, 32'h7FFF_FFFF);                   // R5 + R6
    run_op(2'b11, '0, '0, 32'h8000_0000);                   // R5 + R7
    run_op(2'b11, '0, '0, XW'(-5));                         // R5 floor
    run_op(2'b11, '0, '0, XW'(12345));                      // R5 in range

    // R8: idle cycle with changed inputs holds outputs, valid_o low
    @(negedge clk);
    op_i = 2'b00; a_i = MAXV[W-1:0]; b_i = MAXV[W-1:0]; valid_i = 1'b0;
    @(negedge clk);
    check("R8 hold", last_res, last_ovf, last_unf, 1'b0);

    // R9: reset after activity
    run_op(2'b00, MAXV[W-1:0], W'(1), '0);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check("R9 reset after op", '0, 1'b0, 1'b0, 1'b0);
    rst = 1'b0;

    // Constrained random
    for (int i = 0; i < 400; i++) begin
      logic [1:0] op;
      op = 2'($urandom_range(0, 3));
      run_op(op, pick_operand(), pick_operand(),
             ($urandom_range(0, 1) == 0) ? XW'($urandom) : XW'($signed(W'($urandom)) * 4));
      if ($urandom_range(0, 7) == 0) begin
        @(negedge clk);
        a_i = pick_operand(); valid_i = 1'b0;
        @(negedge clk);
        check("R8 random hold", last_res, last_ovf, last_unf, 1'b0);
      end
    end

    finish_run();
  end
endmodule